// File: doc/BRIEF.md
# Luma Chroma Relative Delay Aligner

This block sits between a video decoder's separated luma and chroma paths and the downstream pixel pipeline. It shifts the two sample streams against each other in time so that they line up at its outputs. Both streams share one clock. A chroma pixel spans two luma clocks, so chroma moves only in steps of two clocks, while luma moves in single clocks.

Both paths carry a fixed base latency `BASE`. A signed offset is added to that base, so a path can be made to run "early" (shorter than the base) or "late" (longer). The offsets come from one of two sources. With automatic selection on, a per-format table picks them from a 2-bit input-format code and the manual fields are ignored. With automatic selection off, a 2-bit luma code and a 3-bit chroma code set them directly.

Each valid strobe travels with its data. After any change to the selected delays, both output valids stay low until the longer of the two delay lines has refilled.

Top module: `lc_delay_align`

## Requirements
- R1: With automatic selection off, the luma code sets the luma offset as follows: 2'b00 gives 0, 2'b01 gives +1 clock (later), 2'b11 gives -1 clock (earlier), and 2'b10 gives -2 clocks (earlier).
- R2: With automatic selection off, the chroma code sets the chroma offset in two-clock steps: 3'b001 gives -4 clocks, 3'b010 gives -2, 3'b011 gives 0, 3'b100 gives +2, 3'b101 gives +4, and 3'b110 gives +6.
- R3: The chroma codes 3'b000 and 3'b111 behave exactly like 3'b011 (no shift).
- R4: While `auto_en` is 1, the values on `y_adj` and `c_adj` have no effect on any output.
- R5: While `auto_en` is 1, the format code selects the offsets. Format 2'b00 (composite) and 2'b11 use luma 0 and chroma 0. Format 2'b01 (separate Y/C) uses luma +1 and chroma +4. Format 2'b10 (component) uses luma +1 and chroma +6.
- R6: Each output valid is its input valid delayed by the same number of clocks as its data, except while the hold of R7 is active.
- R7: When the selected delays change at a clock edge, both output valids stay low for the next M cycles, where M is the larger of the two new delays. The outputs may be valid again from the cycle after that.
- R8: Reset clears both delay lines to zero, drives both output valids low, and sets both delays to `BASE`.
- R9: A path with offset k outputs, in cycle n, the input sample it took in cycle n-(BASE+k).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock shared by both streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| y_in | input | YW | Luma sample |
| y_vld_in | input | 1 | Luma sample valid |
| c_in | input | CW | Chroma sample |
| c_vld_in | input | 1 | Chroma sample valid |
| auto_en | input | 1 | 1 selects offsets from the format table |
| fmt | input | 2 | Input format code used by the table |
| y_adj | input | 2 | Manual luma offset code |
| c_adj | input | 3 | Manual chroma offset code |
| y_out | output | YW | Delayed luma sample |
| y_vld_out | output | 1 | Delayed luma valid, gated by the refill hold |
| c_out | output | CW | Delayed chroma sample |
| c_vld_out | output | 1 | Delayed chroma valid, gated by the refill hold |

## Verification
The bench builds the block with `BASE` = 5 and 8-bit samples. With that base, the earliest chroma setting leaves a delay of one clock, so the first tap of the chain is exercised, and the latest chroma setting reaches the last tap at eleven. Every manual code, every format, and switches between settings of unequal length are driven with random data and gappy valids. This covers the refill hold both when it is set by the luma line and when it is set by the chroma line.

// File: rtl/lc_delay_align.sv
module lc_delay_align #(
  parameter int YW   = 10,
  parameter int CW   = 10,
  parameter int BASE = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [YW-1:0] y_in,
  input  logic          y_vld_in,
  input  logic [CW-1:0] c_in,
  input  logic          c_vld_in,
  input  logic          auto_en,
  input  logic [1:0]    fmt,
  input  logic [1:0]    y_adj,
  input  logic [2:0]    c_adj,
  output logic [YW-1:0] y_out,
  output logic          y_vld_out,
  output logic [CW-1:0] c_out,
  output logic          c_vld_out
);
  localparam int MAXD = BASE + 6;
  localparam int DW   = $clog2(MAXD + 1);

  logic [1:0]    y_code;
  logic [2:0]    c_code;
  int            y_off, c_off;
  logic [DW-1:0] y_nx, c_nx, y_dly, c_dly, hold_len, hold_cnt, y_tap, c_tap;
  logic          chg, live_q;

  logic [YW-1:0]   ysr [MAXD];
  logic [CW-1:0]   csr [MAXD];
  logic [MAXD-1:0] yvsr, cvsr;

  always_comb begin
    if (auto_en) begin
      case (fmt)
        2'b01:   begin y_code = 2'b01; c_code = 3'b101; end
        2'b10:   begin y_code = 2'b01; c_code = 3'b110; end
        default: begin y_code = 2'b00; c_code = 3'b011; end
      endcase
    end else begin
      y_code = y_adj;
      c_code = c_adj;
    end
  end

  always_comb begin
    case (y_code)
      2'b01:   y_off = 1;
      2'b10:   y_off = -2;
      2'b11:   y_off = -1;
      default: y_off = 0;
    endcase
    case (c_code)
      3'b001:  c_off = -4;
      3'b010:  c_off = -2;
      3'b100:  c_off = 2;
      3'b101:  c_off = 4;
      3'b110:  c_off = 6;
      default: c_off = 0;
    endcase
  end

  assign y_nx     = DW'(BASE + y_off);
  assign c_nx     = DW'(BASE + c_off);
  assign chg      = (y_nx != y_dly) || (c_nx != c_dly);
  assign hold_len = (y_nx > c_nx) ? y_nx : c_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_dly    <= DW'(BASE);
      c_dly    <= DW'(BASE);
      hold_cnt <= '0;
      live_q   <= 1'b0;
    end else begin
      y_dly  <= y_nx;
      c_dly  <= c_nx;
      live_q <= 1'b1;
      if (chg)                hold_cnt <= hold_len;
      else if (hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXD; i++) begin
        ysr[i] <= '0;
        csr[i] <= '0;
      end
      yvsr <= '0;
      cvsr <= '0;
    end else begin
      ysr[0] <= y_in;
      csr[0] <= c_in;
      for (int i = 1; i < MAXD; i++) begin
        ysr[i] <= ysr[i-1];
        csr[i] <= csr[i-1];
      end
      yvsr <= {yvsr[MAXD-2:0], y_vld_in};
      cvsr <= {cvsr[MAXD-2:0], c_vld_in};
    end
  end

  assign y_tap     = y_dly - 1'b1;
  assign c_tap     = c_dly - 1'b1;
  assign y_out     = ysr[y_tap];
  assign c_out     = csr[c_tap];
  assign y_vld_out = yvsr[y_tap] && (hold_cnt == 0);
  assign c_vld_out = cvsr[c_tap] && (hold_cnt == 0);

  p_hold_after_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !y_vld_out && !c_vld_out);

  p_hold_counts_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !chg && hold_cnt != 0 |=> hold_cnt == $past(hold_cnt) - 1'b1);

  p_luma_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
    y_dly >= DW'(BASE - 2) && y_dly <= DW'(BASE + 1));

  p_chroma_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    c_dly >= DW'(BASE - 4) && c_dly <= DW'(BASE + 6) && c_dly[0] == 1'(BASE));

  p_auto_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && auto_en && $past(auto_en) && $stable(fmt) |=> $stable(y_dly) && $stable(c_dly));
endmodule

// File: tb/lc_delay_align_tb.sv
module lc_delay_align_tb_top;
  localparam int YW = 8, CW = 8, BASE = 5, MAXD = BASE + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [YW-1:0] y_in = '0;
  logic [CW-1:0] c_in = '0;
  logic y_vld_in = 1'b0, c_vld_in = 1'b0, auto_en = 1'b1;
  logic [1:0] fmt = 2'b00, y_adj = 2'b00;
  logic [2:0] c_adj = 3'b011;
  logic [YW-1:0] y_out;
  logic [CW-1:0] c_out;
  logic y_vld_out, c_vld_out;

  always #2.5 clk = ~clk;

  lc_delay_align #(.YW(YW), .CW(CW), .BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .y_in(y_in), .y_vld_in(y_vld_in),
    .c_in(c_in), .c_vld_in(c_vld_in), .auto_en(auto_en), .fmt(fmt),
    .y_adj(y_adj), .c_adj(c_adj), .y_out(y_out), .y_vld_out(y_vld_out),
    .c_out(c_out), .c_vld_out(c_vld_out));

  int vectors = 0, errors = 0;
  string phase = "R8 reset";
  bit done = 1'b0;

  logic [YW-1:0] yq[$];
  logic [CW-1:0] cq[$];
  logic yvq[$], cvq[$];
  int m_yd = BASE, m_cd = BASE, m_hold = 0;

  function automatic int luma_off(logic [1:0] code);
    if (code == 2'b01) return 1;
    if (code == 2'b10) return -2;
    if (code == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int chroma_off(logic [2:0] code);
    if (code >= 3'b001 && code <= 3'b110) return 2 * (int'(code) - 3);
    return 0;
  endfunction

  task automatic model_reset();
    yq.delete(); cq.delete(); yvq.delete(); cvq.delete();
    for (int i = 0; i < MAXD; i++) begin
      yq.push_back('0); cq.push_back('0); yvq.push_back(1'b0); cvq.push_back(1'b0);
    end
    m_yd = BASE; m_cd = BASE; m_hold = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int yn, cn;
      if (auto_en) begin
        yn = BASE + ((fmt == 2'b01 || fmt == 2'b10) ? 1 : 0);
        cn = BASE + ((fmt == 2'b01) ? 4 : (fmt == 2'b10) ? 6 : 0);
      end else begin
        yn = BASE + luma_off(y_adj);
        cn = BASE + chroma_off(c_adj);
      end
      yq.push_front(y_in); void'(yq.pop_back());
      cq.push_front(c_in); void'(cq.pop_back());
      yvq.push_front(y_vld_in); void'(yvq.pop_back());
      cvq.push_front(c_vld_in); void'(cvq.pop_back());
      if (yn != m_yd || cn != m_cd) m_hold = (yn > cn) ? yn : cn;
      else if (m_hold > 0) m_hold--;
      m_yd = yn; m_cd = cn;
    end
  end

  // R9 / R6 / R7: every output compared each cycle, away from the rising edge
  always @(negedge clk) begin
    if (!done) begin
      logic [YW-1:0] ey;
      logic [CW-1:0] ec;
      logic eyv, ecv;
      bit bad;
      ey = yq[m_yd-1]; ec = cq[m_cd-1];
      eyv = yvq[m_yd-1] && (m_hold == 0);
      ecv = cvq[m_cd-1] && (m_hold == 0);
      bad = 1'b0;
      vectors++;
      if (y_out !== ey) begin bad = 1; $display("FAIL %s (R9) y_out=%0h expected %0h", phase, y_out, ey); end
      if (c_out !== ec) begin bad = 1; $display("FAIL %s (R9) c_out=%0h expected %0h", phase, c_out, ec); end
      if (y_vld_out !== eyv) begin bad = 1; $display("FAIL %s (R6/R7) y_vld_out=%0b expected %0b", phase, y_vld_out, eyv); end
      if (c_vld_out !== ecv) begin bad = 1; $display("FAIL %s (R6/R7) c_vld_out=%0b expected %0b", phase, c_vld_out, ecv); end
      if (bad) errors++;
    end
  end

  bit c_ph = 1'b0;
  task automatic run(string name, int n);
    phase = name;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      y_in = YW'($urandom);
      c_in = CW'($urandom);
      y_vld_in = ($urandom % 8) != 0;
      c_ph = ~c_ph;
      c_vld_in = c_ph && (($urandom % 6) != 0);
    end
  endtask

  task automatic manual(logic [1:0] ya, logic [2:0] ca, string name);
    @(negedge clk);
    auto_en = 1'b0; y_adj = ya; c_adj = ca;
    run(name, 30);
  endtask

  initial begin
    run("R8 reset", 4);
    @(negedge clk); rst_n = 1'b1;
    run("R5 auto composite", 30);
    fmt = 2'b01; run("R5 auto Y/C", 30);
    fmt = 2'b10; run("R5 auto component", 30);
    fmt = 2'b11; run("R5 auto format 11", 30);
    fmt = 2'b01; run("R7 hold luma+chroma change", 20);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      y_adj = 2'(k); c_adj = 3'(k);
      run("R4 auto ignores manual fields", 6);
    end
    manual(2'b00, 3'b011, "R1 luma 00");
    manual(2'b01, 3'b011, "R1 luma 01 late");
    manual(2'b10, 3'b011, "R1 luma 10 two early");
    manual(2'b11, 3'b011, "R1 luma 11 one early");
    manual(2'b00, 3'b001, "R2 chroma 001");
    manual(2'b00, 3'b010, "R2 chroma 010");
    manual(2'b00, 3'b100, "R2 chroma 100");
    manual(2'b00, 3'b101, "R2 chroma 101");
    manual(2'b10, 3'b110, "R2 chroma 110 longest");
    manual(2'b01, 3'b000, "R3 chroma 000 unused");
    manual(2'b01, 3'b111, "R3 chroma 111 unused");
    manual(2'b11, 3'b001, "R7 hold short after long");
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      c_adj = 3'(1 + (k % 6)); y_adj = 2'(k);
      run("R7 back-to-back changes", 2);
    end
    run("R6 valid tracking", 30);
    @(negedge clk); rst_n = 1'b0;
    run("R8 reset mid-stream", 4);
    @(negedge clk); rst_n = 1'b1; auto_en = 1'b1; fmt = 2'b10;
    run("R8 restart from base", 30);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog expired in phase %s: finished=0 expected finished=1", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule